// File: doc/BRIEF.md
# Shared Breakpoint Slot Allocator

This block owns four hardware address-match slots and shares them among any number of insert and remove requests. Each request carries an address, already aligned by its sender, and a 4-bit code that gives the access type and the region length. An insert whose address and code exactly match a slot already in use takes that slot again and adds one to its reference count. Any other insert claims the lowest-numbered free slot. A remove subtracts one from the count of the matching slot and releases the slot when the count reaches zero.

The block keeps a 32-bit control-word image. The image holds two enable bits per slot, a 4-bit code field per slot and a local exact-match flag. The block pulses write strobes so that the address comparators and the control register outside it can be updated. Requests use a valid/ready handshake. Each accepted request gets a single response, one cycle later, that reports success or failure and the slot index that was used. A cleanup request clears all state and does not touch the hardware.

Top module: `bp_slot_alloc`

## Requirements
- R1: After reset, ctrl_image is 0, rsp_valid, addr_we and ctrl_we are low, and req_ready is high.
- R2: The op encodings are 0 = insert, 1 = remove, 2 = cleanup and 3 = illegal. Each request accepted on a rising edge produces exactly one rsp_valid pulse, visible after the next rising edge. The write strobes pulse in that same cycle. rsp_slot is 0 whenever rsp_ok is 0.
- R3: An insert with no matching slot takes the lowest slot whose two enable bits (2i local, 2i+1 global) are both clear. The slot's code goes to ctrl_image[16+4i+3:16+4i], bit 2i and bit 8 are set, and addr_we fires with addr_wsel = i and addr_wdata = the address. ctrl_we fires in the same cycle.
- R4: An insert whose address and code match an occupied slot reports that slot with rsp_ok = 1 and leaves ctrl_image and both strobes unchanged.
- R5: An insert with the same address as an occupied slot but a different code claims a new slot.
- R6: An insert that finds no matching slot and no vacant slot reports rsp_ok = 0 and changes nothing.
- R7: A remove that matches a slot whose count is above 1 reports rsp_ok = 1 and that slot, and fires no strobe.
- R8: A remove that brings a count to zero clears that slot's two enable bits and keeps its code field and bit 8. It fires addr_we with addr_wdata = 0 and ctrl_we in the same cycle.
- R9: A remove that matches no occupied slot (address and code both compared) reports rsp_ok = 0 and changes nothing.
- R10: Bits 15:10 of ctrl_image and every global enable bit (bits 1, 3, 5 and 7) stay 0.
- R11: Cleanup zeroes every address, every count and ctrl_image, reports rsp_ok = 1 and fires no strobe.
- R12: Reference counts saturate at 255. After 256 matching inserts, the slot is released by the 255th remove.
- R13: Op code 3 reports rsp_ok = 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 insert, 1 remove, 2 cleanup, 3 illegal |
| req_addr | input | AW | Aligned address to match |
| req_code | input | 4 | Access type and length code |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | 1 success, 0 failure |
| rsp_slot | output | 2 | Slot used, 0 on failure |
| addr_we | output | 1 | Slot address write strobe |
| addr_wsel | output | 2 | Slot being written |
| addr_wdata | output | AW | Address written, 0 on release |
| ctrl_we | output | 1 | Control register write strobe |
| ctrl_image | output | 32 | Current control-word image |

## Verification
A wrong count or a wrong stored address does not show at once. It shows later, when a remove releases a slot too early or too late (an unexpected or missing write strobe pair), or when an insert fails to reuse a slot and claims a fresh one. A corrupt enable or code field shows in ctrl_image in the cycle after the request. That error then spreads into slot choice and match results on the following requests. The saturation run keeps the count near its ceiling for hundreds of requests, so an off-by-one in the count is caught on the exact remove where it should release the slot.

// File: rtl/bp_slot_alloc.sv
module bp_slot_alloc #(
  parameter int AW   = 32,
  parameter int CNTW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_code,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [1:0]    rsp_slot,
  output logic          addr_we,
  output logic [1:0]    addr_wsel,
  output logic [AW-1:0] addr_wdata,
  output logic          ctrl_we,
  output logic [31:0]   ctrl_image
);
  localparam int NS = 4;
  localparam logic [31:0] RSVD = 32'h0000_FC00;
  localparam logic [CNTW-1:0] CMAX = '1;
  localparam logic [CNTW-1:0] CONE = CNTW'(1);

  logic [AW-1:0]   s_addr [NS];
  logic [CNTW-1:0] s_cnt  [NS];
  logic [NS-1:0]   occ, hit;
  logic            hit_any, vac_any, fire;
  logic [1:0]      hit_idx, vac_idx;
  logic [31:0]     ctrl_alloc, ctrl_free;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign occ[g] = |ctrl_image[2*g +: 2];
    assign hit[g] = occ[g] && (s_addr[g] == req_addr) &&
                    (ctrl_image[16+4*g +: 4] == req_code);
  end

  always_comb begin
    hit_any = 1'b0; hit_idx = 2'd0;
    vac_any = 1'b0; vac_idx = 2'd0;
    for (int i = NS-1; i >= 0; i--) begin
      if (hit[i])  begin hit_any = 1'b1; hit_idx = 2'(i); end
      if (!occ[i]) begin vac_any = 1'b1; vac_idx = 2'(i); end
    end
  end

  always_comb begin
    ctrl_alloc = ctrl_image;
    ctrl_alloc[16+4*vac_idx +: 4] = req_code;
    ctrl_alloc[2*vac_idx] = 1'b1;
    ctrl_alloc[8] = 1'b1;
    ctrl_alloc = ctrl_alloc & ~RSVD;
    ctrl_free = ctrl_image;
    ctrl_free[2*hit_idx +: 2] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        s_addr[i] <= '0;
        s_cnt[i]  <= '0;
      end
      ctrl_image <= '0;
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_slot   <= 2'd0;
      addr_we    <= 1'b0;
      addr_wsel  <= 2'd0;
      addr_wdata <= '0;
      ctrl_we    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      addr_we   <= 1'b0;
      ctrl_we   <= 1'b0;
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= 1'b0;
        rsp_slot  <= 2'd0;
        case (req_op)
          2'd0: begin
            if (hit_any) begin
              if (s_cnt[hit_idx] != CMAX) s_cnt[hit_idx] <= s_cnt[hit_idx] + CONE;
              rsp_ok   <= 1'b1;
              rsp_slot <= hit_idx;
            end else if (vac_any) begin
              s_addr[vac_idx] <= req_addr;
              s_cnt[vac_idx]  <= CONE;
              ctrl_image      <= ctrl_alloc;
              ctrl_we         <= 1'b1;
              addr_we         <= 1'b1;
              addr_wsel       <= vac_idx;
              addr_wdata      <= req_addr;
              rsp_ok          <= 1'b1;
              rsp_slot        <= vac_idx;
            end
          end
          2'd1: begin
            if (hit_any) begin
              rsp_ok   <= 1'b1;
              rsp_slot <= hit_idx;
              if (s_cnt[hit_idx] == CONE) begin
                s_cnt[hit_idx]  <= '0;
                s_addr[hit_idx] <= '0;
                ctrl_image      <= ctrl_free;
                ctrl_we         <= 1'b1;
                addr_we         <= 1'b1;
                addr_wsel       <= hit_idx;
                addr_wdata      <= '0;
              end else begin
                s_cnt[hit_idx] <= s_cnt[hit_idx] - CONE;
              end
            end
          end
          2'd2: begin
            for (int i = 0; i < NS; i++) begin
              s_addr[i] <= '0;
              s_cnt[i]  <= '0;
            end
            ctrl_image <= '0;
            rsp_ok     <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bp_slot_alloc_chk.sv
module bp_slot_alloc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic        addr_we,
  input logic        ctrl_we,
  input logic [31:0] ctrl_image
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_rsp_without_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_strobe_on_success_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we || ctrl_we) |-> (rsp_valid && rsp_ok));

  assert_strobes_paired_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we == ctrl_we);

  assert_fail_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (ctrl_image == $past(ctrl_image)));

  assert_reserved_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_image[15:10] == 6'd0) && (ctrl_image[7] == 1'b0) && (ctrl_image[5] == 1'b0) &&
    (ctrl_image[3] == 1'b0) && (ctrl_image[1] == 1'b0));

  assert_cleanup_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2) |=> (ctrl_image == 32'd0 && !addr_we));
endmodule

bind bp_slot_alloc bp_slot_alloc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .addr_we(addr_we),
  .ctrl_we(ctrl_we), .ctrl_image(ctrl_image)
);

// File: tb/tb_bp_slot_alloc.sv
module tb_bp_slot_alloc;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_code = 4'd0;
  logic rsp_valid, rsp_ok, addr_we, ctrl_we;
  logic [1:0] rsp_slot, addr_wsel;
  logic [AW-1:0] addr_wdata;
  logic [31:0] ctrl_image;

  always #10 clk = ~clk;

  bp_slot_alloc #(.AW(AW), .CNTW(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_code(req_code),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_slot(rsp_slot),
    .addr_we(addr_we), .addr_wsel(addr_wsel), .addr_wdata(addr_wdata),
    .ctrl_we(ctrl_we), .ctrl_image(ctrl_image)
  );

  typedef struct {
    string         tag;
    logic          ok;
    logic [1:0]    slot;
    logic          awe;
    logic [1:0]    asel;
    logic [AW-1:0] adata;
    logic          cwe;
    logic [31:0]   ctrl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_addr [4];
  int            m_cnt  [4];
  logic [31:0]   m_ctrl;

  task automatic chk(input string tag, input bit good, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [3:0] c, input string tag);
    exp_t e;
    int h, v;
    e.tag = tag; e.ok = 1'b0; e.slot = 2'd0; e.awe = 1'b0; e.asel = 2'd0;
    e.adata = '0; e.cwe = 1'b0;
    h = -1; v = -1;
    for (int i = 3; i >= 0; i--) begin
      if (m_ctrl[2*i +: 2] != 2'b00 && m_addr[i] == a && m_ctrl[16+4*i +: 4] == c) h = i;
      if (m_ctrl[2*i +: 2] == 2'b00) v = i;
    end
    case (op)
      2'd0: begin
        if (h >= 0) begin
          if (m_cnt[h] < 255) m_cnt[h]++;
          e.ok = 1'b1; e.slot = 2'(h);
        end else if (v >= 0) begin
          m_addr[v] = a; m_cnt[v] = 1;
          m_ctrl[16+4*v +: 4] = c; m_ctrl[2*v] = 1'b1; m_ctrl[8] = 1'b1;
          e.ok = 1'b1; e.slot = 2'(v); e.awe = 1'b1; e.asel = 2'(v); e.adata = a; e.cwe = 1'b1;
        end
      end
      2'd1: begin
        if (h >= 0) begin
          e.ok = 1'b1; e.slot = 2'(h);
          if (m_cnt[h] == 1) begin
            m_cnt[h] = 0; m_addr[h] = '0; m_ctrl[2*h +: 2] = 2'b00;
            e.awe = 1'b1; e.asel = 2'(h); e.cwe = 1'b1;
          end else m_cnt[h]--;
        end
      end
      2'd2: begin
        for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = 0; end
        m_ctrl = '0; e.ok = 1'b1;
      end
      default: ;
    endcase
    e.ctrl = m_ctrl;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_code = c;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk("R2 unexpected response", 1'b0, 64'(rsp_valid), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " ok"},   rsp_ok == e.ok,       64'(rsp_ok), 64'(e.ok));
          chk({e.tag, " slot"}, rsp_slot == e.slot,   64'(rsp_slot), 64'(e.slot));
          chk({e.tag, " addr_we"}, addr_we == e.awe,  64'(addr_we), 64'(e.awe));
          chk({e.tag, " ctrl_we"}, ctrl_we == e.cwe,  64'(ctrl_we), 64'(e.cwe));
          if (e.awe) begin
            chk({e.tag, " addr_wsel"},  addr_wsel == e.asel,   64'(addr_wsel), 64'(e.asel));
            chk({e.tag, " addr_wdata"}, addr_wdata == e.adata, 64'(addr_wdata), 64'(e.adata));
          end
          chk({e.tag, " ctrl_image"}, ctrl_image == e.ctrl, 64'(ctrl_image), 64'(e.ctrl));
          chk("R10 reserved/global bits", (ctrl_image & 32'h0000_FCAA) == 32'd0,
              64'(ctrl_image & 32'h0000_FCAA), 64'd0);
        end
      end else if (addr_we || ctrl_we) begin
        chk("R2 strobe without response", 1'b0, 64'({addr_we, ctrl_we}), 64'd0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000 && !done) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = 0; end
    m_ctrl = '0;
    repeat (3) @(negedge clk);
    chk("R1 ctrl_image reset", ctrl_image == 32'd0, 64'(ctrl_image), 64'd0);
    chk("R1 strobes reset", {rsp_valid, addr_we, ctrl_we} == 3'b000, 64'({rsp_valid, addr_we, ctrl_we}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    chk("R1 idle", {rsp_valid, addr_we, ctrl_we} == 3'b000, 64'({rsp_valid, addr_we, ctrl_we}), 64'd0);

    send(2'd0, 32'h0000_1000, 4'h1, "R3 first insert");
    send(2'd0, 32'h0000_1000, 4'h1, "R4 reuse");
    send(2'd0, 32'h0000_1000, 4'hD, "R5 same addr other code");
    send(2'd0, 32'h0000_2004, 4'hF, "R3 third slot");
    send(2'd0, 32'h0000_3000, 4'h0, "R3 fourth slot");
    send(2'd0, 32'h0000_4000, 4'h1, "R6 full");
    send(2'd3, 32'h0000_1000, 4'h1, "R13 illegal op");
    send(2'd1, 32'h0000_1000, 4'hD, "R8 release slot1");
    send(2'd1, 32'h0000_1000, 4'h1, "R7 decrement");
    send(2'd1, 32'h0000_1000, 4'h1, "R8 release slot0");
    send(2'd1, 32'h0000_1000, 4'h1, "R9 no match");
    send(2'd1, 32'h0000_2004, 4'h1, "R9 code mismatch");
    send(2'd0, 32'h0000_5000, 4'h7, "R3 lowest vacant");
    send(2'd0, 32'h0000_6000, 4'h3, "R3 next vacant");
    send(2'd2, 32'h0, 4'h0, "R11 cleanup");
    send(2'd1, 32'h0000_2004, 4'hF, "R11 remove after cleanup");
    send(2'd0, 32'h0000_7000, 4'h5, "R11 insert after cleanup");
    for (int k = 0; k < 256; k++) send(2'd0, 32'h0000_8000, 4'h3, "R12 saturating insert");
    for (int k = 0; k < 256; k++) send(2'd1, 32'h0000_8000, 4'h3, "R12 saturating remove");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", q.size() == 0, 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule